// File: doc/BRIEF.md
# Demand-Response Word Channel Controller

This block moves a run of 36-bit words (32 data bits with one odd-parity bit per byte) between a word-addressed memory and a single external device. A transfer is launched with a direction, a byte address and a byte count. The controller then holds its command line high for the whole transfer and steps through the words one at a time. Each word uses a four-phase handshake: the controller raises sync-out, the device answers with sync-in, sync-out falls, and the device then drops sync-in. On a write the controller fetches each word from memory before it raises sync-out. On a read it captures the device data while sync-in is high and stores it before it offers the next sync-out.

The transfer stops when the word count runs out, the device signals end during sync-out, a halt arrives, memory reports a program or protection fault, or an optional gap watchdog fires. The watchdog is armed only if the priority input is high at start. When the transfer stops, command falls, `done` pulses for one cycle, and a 6-bit status word is left on `status` until the next start.

Top module: `wordchan_ctrl`

## Requirements
- R1: A start accepted while idle with a byte count of four or more raises `dev_cmd` one clock later. `dev_cmd` stays high until the transfer terminates, and it falls in the same cycle that `done` pulses. Every termination of an accepted transfer sets status bit 0 (channel end).
- R2: `dev_rd` is 0 for a write (memory to device) and 1 for a read (device to memory), and it does not change while `dev_cmd` is high.
- R3: `dev_sync_out` is high only while `dev_cmd` is high. It rises only after a clock where `dev_sync_in` was sampled low, and it falls on the clock after `dev_sync_in` is sampled high.
- R4: On a write, each word fetched from memory appears unchanged on `dev_odata` while `dev_sync_out` is high. On a read, `dev_idata` is captured on the clock where `dev_sync_in` is seen high, and it is written to consecutive word addresses.
- R5: `dev_end` sampled high while `dev_sync_out` and `dev_cmd` are high drops both lines on the same clock. Status then reads 0x03 (channel end and device end, bit 1).
- R6: Once the last counted word has finished (sync-in low again on a write, memory acknowledge on a read), `dev_cmd` falls instead of a further sync-out. Status reads 0x03, and the number of sync-out pulses equals the count divided by four.
- R7: `halt` sampled high during a transfer drops `dev_cmd` on the next clock, and status reads 0x01.
- R8: A memory acknowledge with `mem_prog_err` high ends the transfer with status 0x05 (bit 2). One with `mem_prot_err` high ends it with status 0x09 (bit 3).
- R9: If `dev_pri_in` is high at start, a gap of TIMEOUT_CYC cycles without a new sync-out rise ends the transfer with status 0x21 (bit 5, interface check). If `dev_pri_in` is low at start, a stalled device holds the transfer open indefinitely.
- R10: On a read, a word whose byte fails odd parity sets status bit 4 unless `dev_sup_par` is high. The word is stored with freshly generated odd parity (bit 32+i covers byte i), and the transfer goes on.
- R11: Bits [1:0] of the start address and of the start count are ignored. A count below four bytes is refused: `dev_cmd` never rises, `done` pulses one clock after start, and status reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a transfer (taken only while idle) |
| start_read | input | 1 | 1 = read from device, 0 = write to device |
| start_addr | input | AW | Byte start address |
| start_count | input | CW | Byte count |
| halt | input | 1 | Stop the running transfer |
| done | output | 1 | One-cycle termination pulse |
| status | output | 6 | Final status: bit0 channel end, bit1 device end, bit2 program, bit3 protection, bit4 data check, bit5 interface check |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | 36 | Write word |
| mem_ack | input | 1 | Access complete; read data and errors valid |
| mem_rdata | input | 36 | Read word |
| mem_prog_err | input | 1 | Program fault with acknowledge |
| mem_prot_err | input | 1 | Protection fault with acknowledge |
| dev_cmd | output | 1 | Command, high for the whole transfer |
| dev_rd | output | 1 | Read/write indicate |
| dev_sync_out | output | 1 | Per-word request |
| dev_odata | output | 36 | Word to device |
| dev_sync_in | input | 1 | Device acknowledge |
| dev_end | input | 1 | Device ends the transfer |
| dev_sup_par | input | 1 | Suppress parity check on read |
| dev_pri_in | input | 1 | Arms the gap watchdog when sampled at start |
| dev_idata | input | 36 | Word from device |

## Verification
The hardest states to reach are the ones where the device is the cause: an end during the second of five sync-out pulses, a device that never answers with the watchdog armed, and the same stall with it disarmed. The bench device model has knobs that pick the word index at which it raises end in place of sync-in, or makes it fall silent. Together with a shortened TIMEOUT_CYC, these reach each termination from the ports. A read whose device data carries one corrupted parity bit, run with and without suppression, shows both the status bit and the regenerated parity in memory.

// File: rtl/wordchan_pkg.sv
package wordchan_pkg;
  localparam int NBYTES  = 4;
  localparam int WORD_W  = NBYTES * 9;
  localparam int STAT_W  = 6;
  localparam int SB_CE   = 0;
  localparam int SB_DE   = 1;
  localparam int SB_PROG = 2;
  localparam int SB_PROT = 3;
  localparam int SB_CDC  = 4;
  localparam int SB_ICC  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RAISE,
    ST_WAIT_IN,
    ST_WAIT_LOW,
    ST_STORE
  } wc_state_e;
endpackage

// File: rtl/wordchan_parity.sv
module wordchan_parity #(
  parameter int NB = 4
) (
  input  logic [NB*9-1:0] word_in,
  output logic            par_ok,
  output logic [NB*9-1:0] word_fixed
);
  logic [NB-1:0] lane_good;
  logic [NB-1:0] lane_par;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_good[b] = ^{word_in[8*b +: 8], word_in[8*NB + b]};
    assign lane_par[b]  = ~^word_in[8*b +: 8];
  end

  assign par_ok     = &lane_good;
  assign word_fixed = {lane_par, word_in[8*NB-1:0]};
endmodule

// File: rtl/wordchan_gap_timer.sv
module wordchan_gap_timer #(
  parameter int LIMIT = 15_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == TW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)             cnt_d = '0;
    else if (run && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(LIMIT)); // R9
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired); // R9
endmodule

// File: rtl/wordchan_ctrl.sv
module wordchan_ctrl
  import wordchan_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CW          = 16,
  parameter int TIMEOUT_CYC = 15_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_read,
  input  logic [AW-1:0]     start_addr,
  input  logic [CW-1:0]     start_count,
  input  logic              halt,
  output logic              done,
  output logic [5:0]        status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-3:0]     mem_addr,
  output logic [35:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [35:0]       mem_rdata,
  input  logic              mem_prog_err,
  input  logic              mem_prot_err,
  output logic              dev_cmd,
  output logic              dev_rd,
  output logic              dev_sync_out,
  output logic [35:0]       dev_odata,
  input  logic              dev_sync_in,
  input  logic              dev_end,
  input  logic              dev_sup_par,
  input  logic              dev_pri_in,
  input  logic [35:0]       dev_idata
);
  localparam int WA = AW - 2;
  localparam int WC = CW - 2;

  wc_state_e          state_q, state_d;
  logic               cmd_q, cmd_d, sync_q, sync_d, rd_q, rd_d;
  logic               armed_q, armed_d, done_q, done_d;
  logic [WA-1:0]      addr_q, addr_d;
  logic [WC-1:0]      words_q, words_d;
  logic [WORD_W-1:0]  data_q, data_d;
  logic [STAT_W-1:0]  stat_q, stat_d;
  logic               fin;
  logic [STAT_W-1:0]  fin_bits;
  logic               tmr_restart, tmr_expired, in_par_ok;
  logic [WORD_W-1:0]  in_fixed;
  logic               unused_low_bits;

  assign unused_low_bits = ^{start_addr[1:0], start_count[1:0]};

  wordchan_parity #(.NB(NBYTES)) u_par (
    .word_in    (dev_idata),
    .par_ok     (in_par_ok),
    .word_fixed (in_fixed)
  );

  wordchan_gap_timer #(.LIMIT(TIMEOUT_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (cmd_q && armed_q),
    .expired (tmr_expired)
  );

  always_comb begin
    state_d     = state_q;
    cmd_d       = cmd_q;
    sync_d      = sync_q;
    rd_d        = rd_q;
    armed_d     = armed_q;
    addr_d      = addr_q;
    words_d     = words_q;
    data_d      = data_q;
    stat_d      = stat_q;
    done_d      = 1'b0;
    fin         = 1'b0;
    fin_bits    = '0;
    tmr_restart = 1'b0;

    if (state_q == ST_IDLE) begin
      if (start) begin
        if (start_count[CW-1:2] == '0) begin
          done_d = 1'b1;
          stat_d = STAT_W'(1) << SB_PROG;
        end else begin
          stat_d      = '0;
          cmd_d       = 1'b1;
          rd_d        = start_read;
          armed_d     = dev_pri_in;
          addr_d      = start_addr[AW-1:2];
          words_d     = start_count[CW-1:2];
          tmr_restart = 1'b1;
          state_d     = start_read ? ST_RAISE : ST_FETCH;
        end
      end
    end else if (halt) begin
      fin = 1'b1;
      fin_bits[SB_CE] = 1'b1;
    end else if (tmr_expired) begin
      fin = 1'b1;
      fin_bits[SB_CE]  = 1'b1;
      fin_bits[SB_ICC] = 1'b1;
    end else begin
      case (state_q)
        ST_FETCH, ST_STORE: begin
          if (mem_ack) begin
            if (mem_prog_err) begin
              fin = 1'b1;
              fin_bits[SB_CE]   = 1'b1;
              fin_bits[SB_PROG] = 1'b1;
            end else if (mem_prot_err) begin
              fin = 1'b1;
              fin_bits[SB_CE]   = 1'b1;
              fin_bits[SB_PROT] = 1'b1;
            end else if (state_q == ST_FETCH) begin
              data_d  = mem_rdata;
              state_d = ST_RAISE;
            end else if (words_q == '0) begin
              fin = 1'b1;
              fin_bits[SB_CE] = 1'b1;
              fin_bits[SB_DE] = 1'b1;
            end else begin
              addr_d  = addr_q + 1'b1;
              state_d = ST_RAISE;
            end
          end
        end
        ST_RAISE: begin
          if (!dev_sync_in) begin
            sync_d      = 1'b1;
            tmr_restart = 1'b1;
            state_d     = ST_WAIT_IN;
          end
        end
        ST_WAIT_IN: begin
          if (dev_end) begin
            fin = 1'b1;
            fin_bits[SB_CE] = 1'b1;
            fin_bits[SB_DE] = 1'b1;
          end else if (dev_sync_in) begin
            sync_d  = 1'b0;
            words_d = words_q - 1'b1;
            if (rd_q) begin
              data_d = in_fixed;
              if (!in_par_ok && !dev_sup_par) stat_d[SB_CDC] = 1'b1;
            end
            state_d = ST_WAIT_LOW;
          end
        end
        ST_WAIT_LOW: begin
          if (!dev_sync_in) begin
            if (rd_q) begin
              state_d = ST_STORE;
            end else if (words_q == '0) begin
              fin = 1'b1;
              fin_bits[SB_CE] = 1'b1;
              fin_bits[SB_DE] = 1'b1;
            end else begin
              addr_d  = addr_q + 1'b1;
              state_d = ST_FETCH;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (fin) begin
      cmd_d   = 1'b0;
      sync_d  = 1'b0;
      done_d  = 1'b1;
      stat_d  = stat_d | fin_bits;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= 1'b0;
      sync_q  <= 1'b0;
      rd_q    <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      words_q <= '0;
      data_q  <= '0;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      sync_q  <= sync_d;
      rd_q    <= rd_d;
      armed_q <= armed_d;
      done_q  <= done_d;
      addr_q  <= addr_d;
      words_q <= words_d;
      data_q  <= data_d;
      stat_q  <= stat_d;
    end
  end

  assign done         = done_q;
  assign status       = stat_q;
  assign dev_cmd      = cmd_q;
  assign dev_rd       = rd_q;
  assign dev_sync_out = sync_q;
  assign dev_odata    = data_q;
  assign mem_req      = (state_q == ST_FETCH) || (state_q == ST_STORE);
  assign mem_we       = (state_q == ST_STORE);
  assign mem_addr     = addr_q;
  assign mem_wdata    = data_q;

  AST_CMD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !dev_cmd && !done && (start_count[CW-1:2] != '0) |=> dev_cmd); // R1
  AST_CMD_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_cmd) |-> done); // R1
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cmd && $past(dev_cmd) |-> $stable(dev_rd)); // R2
  AST_SYNC_UNDER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sync_out |-> dev_cmd); // R3
  AST_SYNC_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_sync_out) |-> $past(!dev_sync_in)); // R3
  AST_SYNC_DROP_ON_IN: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sync_out && dev_sync_in |=> !dev_sync_out); // R3
  AST_END_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cmd && dev_sync_out && dev_end |=> !dev_cmd && !dev_sync_out); // R5
  AST_HALT_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cmd && halt |=> !dev_cmd); // R7
  AST_MEMERR_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (mem_prog_err || mem_prot_err) |=> !dev_cmd); // R8
endmodule

// File: tb/tb_wordchan_ctrl.sv
module tb_wordchan_ctrl;
  localparam int AW  = 16;
  localparam int CW  = 16;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 0, start_read = 0, halt = 0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] start_count = '0;
  logic          done;
  logic [5:0]    status;
  logic          mem_req, mem_we;
  logic [AW-3:0] mem_addr;
  logic [35:0]   mem_wdata;
  logic          mem_ack = 0, mem_prog_err = 0, mem_prot_err = 0;
  logic [35:0]   mem_rdata = '0;
  logic          dev_cmd, dev_rd, dev_sync_out;
  logic [35:0]   dev_odata;
  logic          dev_sync_in = 0, dev_end = 0, dev_sup_par = 0, dev_pri_in = 0;
  logic [35:0]   dev_idata;

  wordchan_ctrl #(.AW(AW), .CW(CW), .TIMEOUT_CYC(TMO)) dut (.*);

  int checks = 0, failures = 0, cyc = 0;
  int silent = 0, end_at = 99, bad_idx = 99, inj_prog = 0, inj_prot = 0;
  int widx = 0, pulses = 0;
  logic prev_so = 0;
  logic [35:0] mem [16];
  logic [35:0] out_log [8];

  function automatic logic [35:0] odd36(input logic [31:0] d);
    return {~^d[31:24], ~^d[23:16], ~^d[15:8], ~^d[7:0], d};
  endfunction

  assign dev_idata = odd36(32'hC0DE_0000 + 32'(widx)) ^
                     ((widx == bad_idx) ? 36'h1_0000_0000 : 36'h0);

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: one-cycle acknowledge
  always @(negedge clk) begin
    mem_ack      <= mem_req && !mem_ack;
    mem_prog_err <= mem_req && !mem_ack && (inj_prog != 0);
    mem_prot_err <= mem_req && !mem_ack && (inj_prot != 0);
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[3:0]];
    end
  end

  // device model: four-phase responder
  always @(negedge clk) begin
    prev_so <= dev_sync_out;
    if (dev_sync_out && !prev_so) pulses <= pulses + 1;
    if (!dev_cmd) begin
      dev_sync_in <= 0; dev_end <= 0; widx <= 0;
    end else if (dev_sync_out && !dev_sync_in && !dev_end) begin
      if (silent != 0) begin end
      else if (end_at == widx) dev_end <= 1;
      else begin
        dev_sync_in <= 1;
        if (widx < 8) out_log[widx] <= dev_odata;
      end
    end else if (!dev_sync_out && dev_sync_in) begin
      dev_sync_in <= 0;
      widx <= widx + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic rd, input logic [AW-1:0] a, input logic [CW-1:0] c,
                        input logic expect_cmd, input string req);
    @(negedge clk);
    start = 1; start_read = rd; start_addr = a; start_count = c;
    @(negedge clk);
    start = 0;
    chk(req, dev_cmd, expect_cmd);
  endtask

  task automatic wait_done(output int cycles);
    int t0 = cyc;
    while (!done && (cyc - t0) < 5000) @(negedge clk);
    cycles = cyc - t0;
    chk("done seen", done, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 reset cmd", dev_cmd, 0);
    chk("R3 reset sync", dev_sync_out, 0);
    chk("R1 reset done", done, 0);
    chk("R4 reset mem_req", mem_req, 0);
  endtask

  task automatic t_write3();
    int c, p0;
    p0 = pulses;
    launch(0, 16'h000B, 16'd15, 1, "R1 cmd rise write");
    chk("R2 write indicate", dev_rd, 0);
    wait_done(c);
    chk("R1 cmd low at done", dev_cmd, 0);
    chk("R6 status write", status, 6'h03);
    chk("R6 pulses write", pulses - p0, 3);
    for (int i = 0; i < 3; i++) chk("R4 R11 write data", out_log[i], mem[2+i]);
  endtask

  task automatic t_read4();
    int c, p0;
    p0 = pulses;
    launch(1, 16'h0021, 16'd16, 1, "R1 cmd rise read");
    chk("R2 read indicate", dev_rd, 1);
    wait_done(c);
    chk("R6 status read", status, 6'h03);
    chk("R6 pulses read", pulses - p0, 4);
    for (int i = 0; i < 4; i++) chk("R4 read store", mem[8+i], odd36(32'hC0DE_0000 + 32'(i)));
  endtask

  task automatic t_parity(input logic sup);
    int c, p0;
    bad_idx = 1; dev_sup_par = sup; p0 = pulses;
    launch(1, 16'h0030, 16'd12, 1, "R10 cmd");
    wait_done(c);
    chk("R10 parity status", status, sup ? 6'h03 : 6'h13);
    chk("R10 continues", pulses - p0, 3);
    for (int i = 0; i < 3; i++) chk("R10 regenerated parity", mem[12+i], odd36(32'hC0DE_0000 + 32'(i)));
    bad_idx = 99; dev_sup_par = 0;
  endtask

  task automatic t_dev_end();
    int c, p0;
    end_at = 1; p0 = pulses;
    launch(0, 16'h0000, 16'd20, 1, "R5 cmd");
    wait_done(c);
    chk("R5 cmd low", dev_cmd, 0);
    chk("R5 sync low together", dev_sync_out, 0);
    chk("R5 status", status, 6'h03);
    chk("R5 pulses", pulses - p0, 2);
    end_at = 99;
  endtask

  task automatic t_halt();
    int c, p0;
    p0 = pulses;
    launch(0, 16'h0000, 16'd20, 1, "R7 cmd");
    repeat (6) @(negedge clk);
    halt = 1;
    @(negedge clk);
    halt = 0;
    chk("R7 cmd drops next clock", dev_cmd, 0);
    chk("R7 done pulse", done, 1);
    chk("R7 status", status, 6'h01);
    chk("R7 cut short", (pulses - p0) < 5, 1);
    c = 0;
  endtask

  task automatic t_memerr();
    int c, p0;
    inj_prog = 1; p0 = pulses;
    launch(0, 16'h0000, 16'd8, 1, "R8 cmd prog");
    wait_done(c);
    chk("R8 prog status", status, 6'h05);
    chk("R8 no pulse", pulses - p0, 0);
    inj_prog = 0; inj_prot = 1;
    launch(1, 16'h0000, 16'd4, 1, "R8 cmd prot");
    wait_done(c);
    chk("R8 prot status", status, 6'h09);
    inj_prot = 0;
  endtask

  task automatic t_timeout();
    int c, p0;
    silent = 1; dev_pri_in = 1; p0 = pulses;
    launch(0, 16'h0000, 16'd8, 1, "R9 cmd");
    dev_pri_in = 0;
    wait_done(c);
    chk("R9 timeout status", status, 6'h21);
    chk("R9 gap length", c >= TMO, 1);
    chk("R9 one pulse", pulses - p0, 1);
    launch(0, 16'h0000, 16'd8, 1, "R9 cmd unarmed");
    repeat (3 * TMO) @(negedge clk);
    chk("R9 no timeout unarmed", dev_cmd, 1);
    halt = 1;
    @(negedge clk);
    halt = 0;
    chk("R9 R7 halt after stall", status, 6'h01);
    silent = 0;
  endtask

  task automatic t_short();
    launch(0, 16'h0000, 16'd3, 0, "R11 short count no cmd");
    chk("R11 done pulse", done, 1);
    chk("R11 status", status, 6'h04);
    @(negedge clk);
    chk("R11 cmd stays low", dev_cmd, 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = odd36(32'h1000_0000 + 32'(i * 32'h111));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_write3();
    t_read4();
    t_parity(0);
    t_parity(1);
    t_dev_end();
    t_halt();
    t_memerr();
    t_timeout();
    t_short();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule